// File: doc/BRIEF.md
# AXI4-Lite to Register Port Bridge Across Clock Domains

This block is a 32-bit AXI4-Lite slave clocked by the processor clock. It turns each bus transaction into a simple access on a register port that runs on a separate, unrelated user clock. The register port has a single word address that reads and writes share, and a one-cycle write strobe with data and byte enables. A read is a one-cycle request strobe, and the slave answers it with data qualified by a one-cycle valid pulse. Because the slave decides when to raise the valid pulse, it sets its own read latency.

A processor-side state machine accepts one transaction at a time. It has the states `B_IDLE`, `B_WR_BUSY`, `B_WR_RESP`, `B_RD_BUSY` and `B_RD_RESP`. In `B_IDLE` a write is accepted (`B_IDLE`→`B_WR_BUSY`) when both the address and the data are offered. Otherwise a read is accepted (`B_IDLE`→`B_RD_BUSY`). When the completion returns, the machine moves `B_WR_BUSY`→`B_WR_RESP` or `B_RD_BUSY`→`B_RD_RESP`. When the master accepts the response, it moves from the response state back to `B_IDLE`.

Each request crosses to the user clock as a toggle through a flop synchroniser. The request fields are held stable in the processor domain while the toggle crosses. A user-side machine has the states `U_IDLE`, `U_WRITE`, `U_RD_REQ` and `U_RD_WAIT`. It moves `U_IDLE`→`U_WRITE`→`U_IDLE` for a write. For a read it moves `U_IDLE`→`U_RD_REQ`, then `U_RD_REQ`→`U_IDLE` if the valid pulse comes at once, or `U_RD_REQ`→`U_RD_WAIT`→`U_IDLE` otherwise. Each finished access returns a toggle to the processor side, and read data comes back through a held crossing register.

Top module: `axreg_bridge`

## Requirements
- R1: After reset, `s_bvalid`, `s_rvalid`, `reg_wr_en` and `reg_rd_req` are low, and no register access occurs until a transaction is offered.
- R2: A write is accepted only in a cycle where `s_awvalid` and `s_wvalid` are both high, with `s_awready` and `s_wready` high together. It produces exactly one single-cycle `reg_wr_en` pulse with `reg_addr` = `s_awaddr` shifted right by two (the two low address bits are dropped), `reg_wr_data` = `s_wdata` and `reg_wr_be` = `s_wstrb`.
- R3: `s_bvalid` rises only after the `reg_wr_en` pulse has occurred. `s_bresp` is 2'b00 (OKAY). `s_bvalid` stays high until a cycle with `s_bready` high, and falls after it.
- R4: A read produces exactly one single-cycle `reg_rd_req` pulse with `reg_addr` = `s_araddr` shifted right by two. `reg_addr` stays constant until `reg_rd_valid` is seen.
- R5: `s_rdata` equals the `reg_rd_data` value present with `reg_rd_valid`, and `s_rresp` is 2'b00 (OKAY). `s_rvalid` and `s_rdata` hold until a cycle with `s_rready` high.
- R6: When a complete write (address and data) and a read are offered in the same idle cycle, the write is accepted and `s_arready` stays low. The read is accepted after the write response completes.
- R7: Only one transaction is in flight. While a response is pending or an access is outstanding, `s_awready`, `s_wready` and `s_arready` stay low, and no further register access starts.
- R8: A write address offered without write data is not accepted and causes no register access until the data arrives.
- R9: The slave's read latency can be zero or more user cycles. A `reg_rd_valid` pulse while no read is outstanding is ignored and produces no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Processor-domain clock |
| aresetn | input | 1 | Processor-domain reset, active low |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| uclk | input | 1 | User-domain clock |
| urst_n | input | 1 | User-domain reset, active low |
| reg_addr | output | ADDR_W-2 | Shared word address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W | Write data |
| reg_wr_be | output | DATA_W/8 | Byte enables; bit n qualifies data bits [8n+7:8n] |
| reg_rd_req | output | 1 | One-cycle read request |
| reg_rd_data | input | DATA_W | Read data from the slave |
| reg_rd_valid | input | 1 | One-cycle read data valid |

## Verification
A table of mixed writes and reads drives the main path. The vectors use aligned, top-of-range and unaligned addresses, partial, full and empty byte enables, slave latencies from zero to several cycles, and response-ready delays. Together they separate address truncation, byte-enable routing, response holding and correct capture of late read data. Directed cases then offer a write address without data, a write and a read together, a write during a long read, and a stray valid pulse with no read outstanding. These show, in turn, the handshake rule, the write-first order, the single-transaction limit and that idle completions are ignored.

// File: rtl/axreg_pkg.sv
package axreg_pkg;

    typedef enum logic [2:0] {
        B_IDLE,
        B_WR_BUSY,
        B_WR_RESP,
        B_RD_BUSY,
        B_RD_RESP
    } bus_state_t;

    typedef enum logic [1:0] {
        U_IDLE,
        U_WRITE,
        U_RD_REQ,
        U_RD_WAIT
    } usr_state_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axreg_tgl_sync.sv
module axreg_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic pulse_o
);
    logic [STAGES:0] chain_q;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= tgl_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign pulse_o = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/axreg_bus_fsm.sv
module axreg_bus_fsm
    import axreg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8,
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [BE_W-1:0]   s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              req_tgl_o,
    output logic              req_is_wr_o,
    output logic [WA_W-1:0]   req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    output logic [BE_W-1:0]   req_be_o,
    input  logic              ack_pulse_i,
    input  logic [DATA_W-1:0] rd_data_i
);
    bus_state_t state_q, state_d;
    logic       wr_take, rd_take;
    logic [DATA_W-1:0] rdata_q;

    // state register
    always_ff @(posedge aclk or negedge aresetn) begin
        if (!aresetn) state_q <= B_IDLE;
        else          state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_take   = (state_q == B_IDLE) && s_awvalid && s_wvalid;
        rd_take   = (state_q == B_IDLE) && s_arvalid && !(s_awvalid && s_wvalid);
        s_awready = wr_take;
        s_wready  = wr_take;
        s_arready = rd_take;
        s_bvalid  = (state_q == B_WR_RESP);
        s_rvalid  = (state_q == B_RD_RESP);
        s_bresp   = RESP_OKAY;
        s_rresp   = RESP_OKAY;
        s_rdata   = rdata_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_IDLE: begin
                if (wr_take)      state_d = B_WR_BUSY;
                else if (rd_take) state_d = B_RD_BUSY;
            end
            B_WR_BUSY: if (ack_pulse_i) state_d = B_WR_RESP;
            B_WR_RESP: if (s_bready)    state_d = B_IDLE;
            B_RD_BUSY: if (ack_pulse_i) state_d = B_RD_RESP;
            B_RD_RESP: if (s_rready)    state_d = B_IDLE;
            default:                    state_d = B_IDLE;
        endcase
    end

    // request fields, held until the next accept
    always_ff @(posedge aclk or negedge aresetn) begin
        if (!aresetn) begin
            req_tgl_o   <= 1'b0;
            req_is_wr_o <= 1'b0;
            req_addr_o  <= '0;
            req_wdata_o <= '0;
            req_be_o    <= '0;
            rdata_q     <= '0;
        end else begin
            if (wr_take) begin
                req_tgl_o   <= ~req_tgl_o;
                req_is_wr_o <= 1'b1;
                req_addr_o  <= WA_W'(s_awaddr >> 2);
                req_wdata_o <= s_wdata;
                req_be_o    <= s_wstrb;
            end else if (rd_take) begin
                req_tgl_o   <= ~req_tgl_o;
                req_is_wr_o <= 1'b0;
                req_addr_o  <= WA_W'(s_araddr >> 2);
            end
            if (state_q == B_RD_BUSY && ack_pulse_i) rdata_q <= rd_data_i;
        end
    end

    p_bvalid_hold_r3: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_bvalid && !s_bready) |=> s_bvalid);
    p_bresp_okay_r3: assert property (@(posedge aclk) disable iff (!aresetn)
        s_bvalid |-> (s_bresp == RESP_OKAY));
    p_rvalid_hold_r5: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
    p_wr_first_r6: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_awready && s_arvalid) |-> !s_arready);
    p_busy_no_accept_r7: assert property (@(posedge aclk) disable iff (!aresetn)
        (s_bvalid || s_rvalid) |-> !(s_awready || s_wready || s_arready));

endmodule

// File: rtl/axreg_usr_fsm.sv
module axreg_usr_fsm
    import axreg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8,
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic              uclk,
    input  logic              urst_n,
    input  logic              req_pulse_i,
    input  logic              req_is_wr_i,
    input  logic [WA_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [BE_W-1:0]   req_be_i,
    output logic              ack_tgl_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [WA_W-1:0]   reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [BE_W-1:0]   reg_wr_be,
    output logic              reg_rd_req,
    input  logic [DATA_W-1:0] reg_rd_data,
    input  logic              reg_rd_valid
);
    usr_state_t state_q, state_d;
    logic       rd_open;

    // state register
    always_ff @(posedge uclk or negedge urst_n) begin
        if (!urst_n) state_q <= U_IDLE;
        else         state_q <= state_d;
    end

    // outputs
    always_comb begin
        reg_wr_en  = (state_q == U_WRITE);
        reg_rd_req = (state_q == U_RD_REQ);
        rd_open    = (state_q == U_RD_REQ) || (state_q == U_RD_WAIT);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE: begin
                if (req_pulse_i) state_d = req_is_wr_i ? U_WRITE : U_RD_REQ;
            end
            U_WRITE:   state_d = U_IDLE;
            U_RD_REQ:  state_d = reg_rd_valid ? U_IDLE : U_RD_WAIT;
            U_RD_WAIT: if (reg_rd_valid) state_d = U_IDLE;
            default:   state_d = U_IDLE;
        endcase
    end

    // port registers, completion toggle and returned data
    always_ff @(posedge uclk or negedge urst_n) begin
        if (!urst_n) begin
            reg_addr    <= '0;
            reg_wr_data <= '0;
            reg_wr_be   <= '0;
            ack_tgl_o   <= 1'b0;
            rd_data_o   <= '0;
        end else begin
            if (state_q == U_IDLE && req_pulse_i) begin
                reg_addr <= req_addr_i;
                if (req_is_wr_i) begin
                    reg_wr_data <= req_wdata_i;
                    reg_wr_be   <= req_be_i;
                end
            end
            if (state_q == U_WRITE) ack_tgl_o <= ~ack_tgl_o;
            if (rd_open && reg_rd_valid) begin
                rd_data_o <= reg_rd_data;
                ack_tgl_o <= ~ack_tgl_o;
            end
        end
    end

    p_wr_single_r2: assert property (@(posedge uclk) disable iff (!urst_n)
        reg_wr_en |=> !reg_wr_en);
    p_rdreq_single_r4: assert property (@(posedge uclk) disable iff (!urst_n)
        reg_rd_req |=> !reg_rd_req);
    p_addr_hold_r4: assert property (@(posedge uclk) disable iff (!urst_n)
        (rd_open && !reg_rd_valid) |=> $stable(reg_addr));
    p_one_access_r7: assert property (@(posedge uclk) disable iff (!urst_n)
        rd_open |-> !reg_wr_en);

endmodule

// File: rtl/axreg_bridge.sv
module axreg_bridge #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int BE_W       = DATA_W / 8,
    localparam int WA_W       = ADDR_W - 2
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [BE_W-1:0]   s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic              uclk,
    input  logic              urst_n,
    output logic [WA_W-1:0]   reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [BE_W-1:0]   reg_wr_be,
    output logic              reg_rd_req,
    input  logic [DATA_W-1:0] reg_rd_data,
    input  logic              reg_rd_valid
);
    logic              req_tgl, req_is_wr, req_pulse;
    logic [WA_W-1:0]   req_addr;
    logic [DATA_W-1:0] req_wdata, usr_rdata;
    logic [BE_W-1:0]   req_be;
    logic              ack_tgl, ack_pulse;

    axreg_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus (
        .aclk(aclk), .aresetn(aresetn),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .req_tgl_o(req_tgl), .req_is_wr_o(req_is_wr), .req_addr_o(req_addr),
        .req_wdata_o(req_wdata), .req_be_o(req_be),
        .ack_pulse_i(ack_pulse), .rd_data_i(usr_rdata)
    );

    axreg_tgl_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk(uclk), .rst_n(urst_n), .tgl_i(req_tgl), .pulse_o(req_pulse)
    );

    axreg_tgl_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk(aclk), .rst_n(aresetn), .tgl_i(ack_tgl), .pulse_o(ack_pulse)
    );

    axreg_usr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_usr (
        .uclk(uclk), .urst_n(urst_n),
        .req_pulse_i(req_pulse), .req_is_wr_i(req_is_wr), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_be_i(req_be),
        .ack_tgl_o(ack_tgl), .rd_data_o(usr_rdata),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
        .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid)
    );

endmodule

// File: tb/test_axreg_bridge.sv
module test_axreg_bridge;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int WA_W   = ADDR_W - 2;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [3:0]  dly;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0000, 32'hA5A5_0001, 4'hF, 4'd0},
        '{1'b1, 16'h00FC, 32'h1234_5678, 4'h3, 4'd3},
        '{1'b0, 16'h0004, 32'hCAFE_0001, 4'h0, 4'd0},
        '{1'b0, 16'h0200, 32'h8000_0001, 4'h0, 4'd5},
        '{1'b1, 16'hFFFC, 32'hFFFF_FFFF, 4'h8, 4'd1},
        '{1'b0, 16'hFFFC, 32'h0000_0000, 4'h0, 4'd2},
        '{1'b1, 16'h0013, 32'h0BAD_F00D, 4'h0, 4'd0},
        '{1'b0, 16'h0123, 32'h0000_0007, 4'h0, 4'd1}
    };

    logic aclk = 1'b0, uclk = 1'b0;
    logic aresetn = 1'b0, urst_n = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [BE_W-1:0]   wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [DATA_W-1:0] rdata;
    logic [WA_W-1:0] reg_addr;
    logic reg_wr_en, reg_rd_req;
    logic [DATA_W-1:0] reg_wr_data;
    logic [BE_W-1:0] reg_wr_be;
    logic [DATA_W-1:0] reg_rd_data = '0;
    logic reg_rd_valid = 1'b0;

    int n_chk = 0, n_fail = 0;
    int wr_seen = 0, rd_seen = 0;
    logic [WA_W-1:0] lw_addr, lr_addr;
    logic [DATA_W-1:0] lw_data;
    logic [BE_W-1:0] lw_be;
    logic addr_moved = 1'b0;
    int slave_lat = 0;
    logic [DATA_W-1:0] slave_rdata = '0;
    logic inject = 1'b0;

    always #2   uclk = ~uclk;
    always #3.5 aclk = ~aclk;

    axreg_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_axreg_bridge (
        .aclk(aclk), .aresetn(aresetn),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .uclk(uclk), .urst_n(urst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
        .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // register slave model on the user clock
    initial begin
        forever begin
            @(negedge uclk);
            if (reg_wr_en) begin
                wr_seen++;
                lw_addr = reg_addr; lw_data = reg_wr_data; lw_be = reg_wr_be;
            end
            if (inject) begin
                reg_rd_data = 32'hDEAD_BEEF; reg_rd_valid = 1'b1;
                @(negedge uclk); reg_rd_valid = 1'b0;
            end else if (reg_rd_req) begin
                rd_seen++;
                lr_addr = reg_addr;
                for (int i = 0; i < slave_lat; i++) begin
                    @(negedge uclk);
                    if (reg_addr !== lr_addr) addr_moved = 1'b1;
                end
                reg_rd_data = slave_rdata; reg_rd_valid = 1'b1;
                @(negedge uclk); reg_rd_valid = 1'b0;
            end
        end
    end

    task automatic axi_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be, input int hold);
        int w0;
        w0 = wr_seen;
        @(negedge aclk);
        awaddr = a; wdata = d; wstrb = be; awvalid = 1'b1; wvalid = 1'b1;
        #1;
        while (!awready) begin @(negedge aclk); #1; end
        chk(wready, "R2 wready with awready", 64'(wready), 64'd1);
        @(negedge aclk); awvalid = 1'b0; wvalid = 1'b0;
        while (!bvalid) @(negedge aclk);
        chk(wr_seen == w0 + 1, "R3 strobe before bvalid", 64'(wr_seen - w0), 64'd1);
        chk(lw_addr == a[15:2] && lw_data == d && lw_be == be, "R2 strobe fields",
            {lw_be, lw_addr, 14'h0, lw_data}, {be, a[15:2], 14'h0, d});
        chk(bresp == 2'b00, "R3 bresp OKAY", 64'(bresp), 64'd0);
        repeat (hold) @(negedge aclk);
        chk(bvalid, "R3 bvalid held", 64'(bvalid), 64'd1);
        bready = 1'b1;
        @(negedge aclk); bready = 1'b0;
        chk(!bvalid, "R3 bvalid falls", 64'(bvalid), 64'd0);
    endtask

    task automatic axi_read(input logic [15:0] a, input logic [31:0] d, input int lat, input int hold);
        int r0;
        r0 = rd_seen;
        slave_lat = lat; slave_rdata = d;
        @(negedge aclk);
        araddr = a; arvalid = 1'b1;
        #1;
        while (!arready) begin @(negedge aclk); #1; end
        @(negedge aclk); arvalid = 1'b0;
        while (!rvalid) @(negedge aclk);
        chk(rd_seen == r0 + 1 && lr_addr == a[15:2], "R4 read request address",
            64'(lr_addr), 64'(a[15:2]));
        chk(!addr_moved, "R4 address stable", 64'(addr_moved), 64'd0);
        chk(rdata == d && rresp == 2'b00, "R5 rdata and OKAY", {30'h0, rresp, rdata}, 64'(d));
        repeat (hold) @(negedge aclk);
        chk(rvalid && rdata == d, "R5 rvalid/rdata held", 64'(rdata), 64'(d));
        rready = 1'b1;
        @(negedge aclk); rready = 1'b0;
        chk(!rvalid, "R5 rvalid falls", 64'(rvalid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge aclk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w0, r0;
        logic ok;
        repeat (4) @(negedge aclk);
        aresetn = 1'b1;
        @(negedge uclk); urst_n = 1'b1;
        repeat (10) @(negedge aclk);
        // R1 reset state
        chk(!bvalid && !rvalid && !reg_wr_en && !reg_rd_req && wr_seen == 0 && rd_seen == 0,
            "R1 idle after reset", {bvalid, rvalid, reg_wr_en, reg_rd_req}, 64'd0);

        // table-driven main path (R2 R3 R4 R5 R9 latencies)
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) axi_write(VECS[k].addr, VECS[k].data, VECS[k].be, int'(VECS[k].dly));
            else            axi_read(VECS[k].addr, VECS[k].data, int'(VECS[k].dly), int'(VECS[k].dly));
        end

        // R8: address without data
        w0 = wr_seen; ok = 1'b1;
        @(negedge aclk); awaddr = 16'h0040; awvalid = 1'b1;
        repeat (12) begin #1; if (awready || wready) ok = 1'b0; @(negedge aclk); end
        chk(ok && wr_seen == w0, "R8 no accept without data", 64'(wr_seen - w0), 64'd0);
        awvalid = 1'b0;
        axi_write(16'h0040, 32'h0000_4040, 4'h5, 0);

        // R6: write and read together
        w0 = wr_seen; r0 = rd_seen; slave_lat = 1; slave_rdata = 32'h6666_0006;
        @(negedge aclk);
        awaddr = 16'h0008; wdata = 32'h5555_0005; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
        araddr = 16'h000C; arvalid = 1'b1;
        #1;
        chk(awready && !arready, "R6 write wins", {awready, arready}, 64'b10);
        @(negedge aclk); awvalid = 1'b0; wvalid = 1'b0;
        while (!bvalid) @(negedge aclk);
        chk(wr_seen == w0 + 1 && rd_seen == r0, "R6 write served first",
            64'(rd_seen - r0), 64'd0);
        bready = 1'b1; @(negedge aclk); bready = 1'b0;
        #1; while (!arready) begin @(negedge aclk); #1; end
        @(negedge aclk); arvalid = 1'b0;
        while (!rvalid) @(negedge aclk);
        chk(rdata == 32'h6666_0006 && lr_addr == 14'h3, "R6 read after write", 64'(rdata), 64'h6666_0006);
        rready = 1'b1; @(negedge aclk); rready = 1'b0;

        // R7: write offered during a long read
        w0 = wr_seen; slave_lat = 10; slave_rdata = 32'h7777_0007; ok = 1'b1;
        @(negedge aclk); araddr = 16'h0010; arvalid = 1'b1;
        #1; while (!arready) begin @(negedge aclk); #1; end
        @(negedge aclk); arvalid = 1'b0;
        awaddr = 16'h0014; wdata = 32'h7777_1111; wstrb = 4'h2; awvalid = 1'b1; wvalid = 1'b1;
        while (!rvalid) begin #1; if (awready || arready) ok = 1'b0; @(negedge aclk); end
        repeat (3) begin #1; if (awready) ok = 1'b0; @(negedge aclk); end
        chk(ok && wr_seen == w0, "R7 no accept while busy", 64'(wr_seen - w0), 64'd0);
        chk(rdata == 32'h7777_0007, "R9 long latency data", 64'(rdata), 64'h7777_0007);
        rready = 1'b1; @(negedge aclk); rready = 1'b0;
        #1; while (!awready) begin @(negedge aclk); #1; end
        @(negedge aclk); awvalid = 1'b0; wvalid = 1'b0;
        while (!bvalid) @(negedge aclk);
        chk(wr_seen == w0 + 1 && lw_addr == 14'h5 && lw_be == 4'h2, "R7 queued write done",
            64'(lw_addr), 64'h5);
        bready = 1'b1; @(negedge aclk); bready = 1'b0;

        // R9: stray valid with no read outstanding
        @(negedge uclk); #1 inject = 1'b1;
        @(negedge uclk); #1 inject = 1'b0;
        ok = 1'b1;
        repeat (20) begin @(negedge aclk); if (rvalid || bvalid) ok = 1'b0; end
        chk(ok, "R9 stray valid ignored", 64'(rvalid), 64'd0);
        axi_read(16'h0020, 32'h0909_0909, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule